// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is a single-cycle arithmetic and logic unit for a small micro-sequenced processor. An opcode selects one of sixteen operations on two byte operands, `x_i` and `y_i`. The byte result and three condition flags (sign, overflow, zero) appear combinationally in the same cycle. A divide-by-zero indication also appears in that cycle.

A registered status byte keeps the flags for later conditional branching. When `flag_we_i` is high at a clock edge, the three flag bits of that byte are loaded from the current flags. All other status bits keep their value.

Overflow has one meaning for every operation: the exact, unbounded integer result does not lie in 0..255. The result port always carries the low byte of that exact result. Single-operand operations read only `x_i`.

Top module: `alu8_unit`

## Requirements
- R1: Opcode encoding on `op_i`: 0 NOP, 1 ADD, 2 SUB, 3 MUL, 4 DIV, 5 MOD, 6 INC, 7 DEC, 8 OR, 9 XOR, 10 AND, 11 NOT, 12 SHR, 13 SHL, 14 ROR, 15 ROL. ADD, SUB and MUL return the low byte of the exact x+y, x-y and x*y.
- R2: For ADD, SUB, MUL, INC and DEC, `ovf_o` is 1 exactly when the exact result lies outside 0..255. Examples: 10+0xFB gives 5 with overflow, 0-10 gives 0xF6 with overflow, 0x80*2 gives 0 with overflow.
- R3: `sgn_o` equals bit 7 of `res_o`, and `zro_o` is 1 exactly when `res_o` is 0x00.
- R4: DIV and MOD treat both operands as unsigned and never overflow. Examples: 0xF6/2 = 0x7B, 10/0xFF = 0.
- R5: DIV or MOD with `y_i` = 0 gives `res_o` = 0x00 and `div_err_o` = 1. The status byte is not written at the next edge even if `flag_we_i` is high. For every other case `div_err_o` is 0.
- R6: INC and DEC return x+1 and x-1 and ignore `y_i`. 0xFF+1 gives 0 with overflow, and 0-1 gives 0xFF with overflow.
- R7: SHR shifts X right one place with a zero fill, SHL shifts it left one place with a zero fill, and both ignore `y_i`. SHL sets overflow exactly when bit 7 of X is 1.
- R8: ROR and ROL rotate X by one place: 0x01 ROR gives 0x80, 0xF0 ROL gives 0xE1.
- R9: OR, XOR, AND and NOT (NOT = bitwise inversion of X) give the bitwise result. These four, plus SHR, ROR and ROL, always give `ovf_o` = 0.
- R10: On a rising edge where `flag_we_i` is 1, the opcode is not NOP and `div_err_o` is 0, status bit 3 takes the sign flag, bit 2 the overflow flag and bit 1 the zero flag. Bits 7..4 and 0 keep their value.
- R11: NOP gives `res_o` = 0x00 and never writes the status byte. The status byte also holds whenever `flag_we_i` is 0.
- R12: While `rst_n` is low, the status byte equals the parameter `RST_STATUS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select |
| x_i | input | 8 | First operand |
| y_i | input | 8 | Second operand |
| flag_we_i | input | 1 | Load flags into the status byte at the next edge |
| res_o | output | 8 | Result byte |
| sgn_o | output | 1 | Sign flag of the current result |
| ovf_o | output | 1 | Overflow flag of the current result |
| zro_o | output | 1 | Zero flag of the current result |
| div_err_o | output | 1 | Divide by zero on DIV or MOD |
| status_o | output | 8 | Registered status byte |

## Verification
The bench builds the block with `W` = 8 and `RST_STATUS` = 8'hA1. That reset value puts ones in bits 7, 5 and 0, which are never written by a flag load. A pass-through fault that zeroes or overwrites those bits is therefore visible on `status_o`. With a reset value of zero, the same fault would look like correct behaviour. Random opcodes and operands, combined with a randomly toggled write enable, exercise loads and holds of the status byte from many prior values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_MUL = 4'd3,
    OP_DIV = 4'd4,
    OP_MOD = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_OR  = 4'd8,
    OP_XOR = 4'd9,
    OP_AND = 4'd10,
    OP_NOT = 4'd11,
    OP_SHR = 4'd12,
    OP_SHL = 4'd13,
    OP_ROR = 4'd14,
    OP_ROL = 4'd15
  } alu_op_e;

  // Status byte positions read by the sequencer branch logic
  localparam int unsigned SGN_BIT = 3;
  localparam int unsigned OVF_BIT = 2;
  localparam int unsigned ZRO_BIT = 1;

  typedef struct packed {
    logic sgn;
    logic ovf;
    logic zro;
  } alu_flags_t;

endpackage

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [W-1:0]   res,
  output logic           ovf_raw,
  output logic           div_zero
);

  localparam int unsigned WX = W + 1;
  localparam int unsigned WP = 2 * W;
  localparam logic [WX-1:0] ONE_X = WX'(1);
  localparam logic [W-1:0]  ONE_W = W'(1);

  // Sum widened by one bit; top bit is the carry out
  function automatic logic [WX-1:0] f_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // Difference widened by one bit; top bit is the borrow
  function automatic logic [WX-1:0] f_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction

  function automatic logic [WP-1:0] f_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  function automatic logic [W-1:0] f_rotr(input logic [W-1:0] a);
    return {a[0], a[W-1:1]};
  endfunction

  function automatic logic [W-1:0] f_rotl(input logic [W-1:0] a);
    return {a[W-2:0], a[W-1]};
  endfunction

  logic [WX-1:0] add_w, sub_w, inc_w, dec_w;
  logic [WP-1:0] prod_w;
  logic [W-1:0]  divisor, quot, rem;
  logic          y_nz;

  assign add_w   = f_add(x, y);
  assign sub_w   = f_sub(x, y);
  assign inc_w   = {1'b0, x} + ONE_X;
  assign dec_w   = {1'b0, x} - ONE_X;
  assign prod_w  = f_mul(x, y);
  assign y_nz    = |y;
  // Keep the divider away from a zero divisor; the result is masked anyway
  assign divisor = y_nz ? y : ONE_W;
  assign quot    = x / divisor;
  assign rem     = x % divisor;

  always_comb begin
    res      = '0;
    ovf_raw  = 1'b0;
    div_zero = 1'b0;
    case (op)
      OP_NOP: res = '0;
      OP_ADD: begin res = add_w[W-1:0]; ovf_raw = add_w[W]; end
      OP_SUB: begin res = sub_w[W-1:0]; ovf_raw = sub_w[W]; end
      OP_MUL: begin res = prod_w[W-1:0]; ovf_raw = |prod_w[WP-1:W]; end
      OP_DIV: begin res = y_nz ? quot : '0; div_zero = ~y_nz; end
      OP_MOD: begin res = y_nz ? rem : '0; div_zero = ~y_nz; end
      OP_INC: begin res = inc_w[W-1:0]; ovf_raw = inc_w[W]; end
      OP_DEC: begin res = dec_w[W-1:0]; ovf_raw = dec_w[W]; end
      OP_OR:  res = x | y;
      OP_XOR: res = x ^ y;
      OP_AND: res = x & y;
      OP_NOT: res = ~x;
      OP_SHR: res = {1'b0, x[W-1:1]};
      OP_SHL: begin res = {x[W-2:0], 1'b0}; ovf_raw = x[W-1]; end
      OP_ROR: res = f_rotr(x);
      OP_ROL: res = f_rotl(x);
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu8_flaggen.sv
module alu8_flaggen
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res,
  input  logic         ovf_raw,
  output alu_flags_t   flags
);

  always_comb begin
    flags.sgn = res[W-1];
    flags.ovf = ovf_raw;
    flags.zro = ~|res;
  end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int unsigned SW         = 8,
  parameter logic [SW-1:0] RST_STATUS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  alu_flags_t    flags,
  output logic [SW-1:0] status
);

  logic [SW-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RST_STATUS;
    end else if (wr_en) begin
      status_q[SGN_BIT] <= flags.sgn;
      status_q[OVF_BIT] <= flags.ovf;
      status_q[ZRO_BIT] <= flags.zro;
    end
  end

  assign status = status_q;

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int unsigned  W          = 8,
  parameter logic [7:0]   RST_STATUS = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         flag_we_i,
  output logic [W-1:0] res_o,
  output logic         sgn_o,
  output logic         ovf_o,
  output logic         zro_o,
  output logic         div_err_o,
  output logic [7:0]   status_o
);

  alu_op_e    op_e;
  logic       ovf_raw;
  logic       div_zero;
  alu_flags_t flags;
  logic       stat_wr;   // named event: a flag load happens at this edge

  assign op_e = alu_op_e'(op_i);

  alu8_datapath #(.W(W)) u_dp (
    .op       (op_e),
    .x        (x_i),
    .y        (y_i),
    .res      (res_o),
    .ovf_raw  (ovf_raw),
    .div_zero (div_zero)
  );

  alu8_flaggen #(.W(W)) u_fg (
    .res     (res_o),
    .ovf_raw (ovf_raw),
    .flags   (flags)
  );

  assign stat_wr = flag_we_i & ~div_zero & (op_e != OP_NOP);

  alu8_status #(.SW(8), .RST_STATUS(RST_STATUS)) u_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (stat_wr),
    .flags  (flags),
    .status (status_o)
  );

  assign sgn_o     = flags.sgn;
  assign ovf_o     = flags.ovf;
  assign zro_o     = flags.zro;
  assign div_err_o = div_zero;

endmodule

// File: rtl/alu8_unit_chk.sv
module alu8_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_i,
  input logic [W-1:0] y_i,
  input logic         flag_we_i,
  input logic [W-1:0] res_o,
  input logic         sgn_o,
  input logic         ovf_o,
  input logic         zro_o,
  input logic         div_err_o,
  input logic [7:0]   status_o
);

  localparam logic [7:0] FLAG_MASK = 8'b0000_1110;

  logic is_div, load_ok;
  assign is_div  = (op_i == 4'd4) || (op_i == 4'd5);
  assign load_ok = flag_we_i && (op_i != 4'd0) && !div_err_o;

  a_r10_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (status_o[3] == $past(sgn_o)) && (status_o[2] == $past(ovf_o))
                && (status_o[1] == $past(zro_o)));

  a_r10_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> ((status_o & ~FLAG_MASK) == ($past(status_o) & ~FLAG_MASK)));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ok |=> $stable(status_o));

  a_r5_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (is_div && (y_i == '0)) |-> (div_err_o && (res_o == '0)));

  a_r5_err_only_div: assert property (@(posedge clk) disable iff (!rst_n)
    div_err_o |-> (is_div && !ovf_o));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i >= 4'd8) && (op_i != 4'd13)) |-> !ovf_o);

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    zro_o == (res_o == '0));

  a_r3_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sgn_o == res_o[W-1]);

endmodule

bind alu8_unit alu8_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_i      (op_i),
  .y_i       (y_i),
  .flag_we_i (flag_we_i),
  .res_o     (res_o),
  .sgn_o     (sgn_o),
  .ovf_o     (ovf_o),
  .zro_o     (zro_o),
  .div_err_o (div_err_o),
  .status_o  (status_o)
);

// File: tb/alu8_unit_tb.sv
module alu8_unit_tb;

  localparam logic [7:0] RST_VAL = 8'hA1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] x_i = '0, y_i = '0;
  logic       flag_we_i = 1'b0;
  logic [7:0] res_o, status_o;
  logic       sgn_o, ovf_o, zro_o, div_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] exp_stat;

  always #2 clk = ~clk;

  alu8_unit #(.W(8), .RST_STATUS(RST_VAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .x_i(x_i), .y_i(y_i),
    .flag_we_i(flag_we_i), .res_o(res_o), .sgn_o(sgn_o), .ovf_o(ovf_o),
    .zro_o(zro_o), .div_err_o(div_err_o), .status_o(status_o));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s op=%0d x=%02h y=%02h actual=%0h expected=%0h",
               req, op_i, x_i, y_i, act, exp);
    end
  endtask

  // Exact integer result, then reduce to a byte and judge range
  task automatic model(input logic [3:0] op, input logic [7:0] x, input logic [7:0] y,
                       output logic [7:0] r, output bit v, output bit dz);
    int xi, yi, full;
    xi = int'(x); yi = int'(y); dz = 0; full = 0;
    case (op)
      4'd1:  full = xi + yi;
      4'd2:  full = xi - yi;
      4'd3:  full = xi * yi;
      4'd4:  begin dz = (yi == 0); full = dz ? 0 : xi / yi; end
      4'd5:  begin dz = (yi == 0); full = dz ? 0 : xi % yi; end
      4'd6:  full = xi + 1;
      4'd7:  full = xi - 1;
      4'd8:  full = int'(x | y);
      4'd9:  full = int'(x ^ y);
      4'd10: full = int'(x & y);
      4'd11: full = 255 - xi;
      4'd12: full = xi / 2;
      4'd13: full = xi * 2;
      4'd14: full = (xi / 2) + ((xi % 2) * 128);
      4'd15: full = ((xi * 2) % 256) + (xi / 128);
      default: full = 0;
    endcase
    v = (full < 0) || (full > 255);
    r = 8'(full & 255);
  endtask

  task automatic run(input logic [3:0] op, input logic [7:0] x, input logic [7:0] y,
                     input bit we, input string req);
    logic [7:0] r; bit v, dz;
    @(negedge clk);
    op_i = op; x_i = x; y_i = y; flag_we_i = we;
    #1;
    model(op, x, y, r, v, dz);
    check({req, " result"}, res_o, r);
    check({req, " ovf"}, ovf_o, v);
    check({req, " R3 sign"}, sgn_o, r[7]);
    check({req, " R3 zero"}, zro_o, (r == 8'h00));
    check({req, " R5 div_err"}, div_err_o, dz);
    if (we && !dz && op != 4'd0) begin
      exp_stat[3] = r[7]; exp_stat[2] = v; exp_stat[1] = (r == 8'h00);
    end
    @(posedge clk); #1;
    check({req, " R10/R11 status"}, status_o, exp_stat);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    exp_stat = RST_VAL;
    repeat (3) @(posedge clk);
    #1 check("R12 reset status", status_o, RST_VAL);
    @(negedge clk); rst_n = 1'b1;
    // R1 R2 add/sub/mul
    run(4'd1, 8'd10, 8'hFB, 1, "R2 add wrap");
    run(4'd1, 8'd5, 8'hF6, 1, "R1 add");
    run(4'd2, 8'd0, 8'd10, 1, "R2 sub borrow");
    run(4'd2, 8'hFF, 8'hFF, 1, "R1 sub zero");
    run(4'd3, 8'h80, 8'd2, 1, "R2 mul wrap");
    run(4'd3, 8'd4, 8'd16, 1, "R1 mul");
    // R4 unsigned divide
    run(4'd4, 8'hF6, 8'd2, 1, "R4 div");
    run(4'd4, 8'd10, 8'hFF, 1, "R4 div small");
    run(4'd5, 8'hAC, 8'h10, 1, "R4 mod");
    // R5 divide by zero with write enable high: status must hold
    run(4'd2, 8'd0, 8'd10, 1, "R5 preload");
    run(4'd4, 8'd5, 8'd0, 1, "R5 div by zero");
    run(4'd5, 8'd7, 8'd0, 1, "R5 mod by zero");
    // R6 single operand, Y varied
    run(4'd6, 8'hFF, 8'h00, 1, "R6 inc wrap");
    run(4'd6, 8'hFF, 8'h5A, 1, "R6 inc y ignored");
    run(4'd7, 8'h00, 8'hC3, 1, "R6 dec wrap");
    // R7 shifts, R8 rotates, R9 logic
    run(4'd12, 8'hFF, 8'h33, 1, "R7 shr");
    run(4'd13, 8'hF0, 8'h01, 1, "R7 shl ovf");
    run(4'd13, 8'h0F, 8'hFF, 1, "R7 shl");
    run(4'd14, 8'h01, 8'h00, 1, "R8 ror");
    run(4'd15, 8'hF0, 8'h00, 1, "R8 rol");
    run(4'd11, 8'h0F, 8'h99, 1, "R9 not");
    run(4'd9, 8'h3C, 8'hC3, 1, "R9 xor");
    run(4'd10, 8'hF0, 8'h0F, 1, "R9 and");
    run(4'd8, 8'h00, 8'h01, 1, "R9 or");
    // R11 NOP and disabled write
    run(4'd2, 8'd0, 8'd1, 1, "R11 preload");
    run(4'd0, 8'h12, 8'h34, 1, "R11 nop");
    run(4'd1, 8'd0, 8'd0, 0, "R11 we low");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] rop; logic [7:0] rx, ry; bit rwe;
      rop = 4'($urandom_range(0, 15));
      rx  = 8'($urandom_range(0, 255));
      ry  = ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
      rwe = 1'($urandom_range(0, 1));
      run(rop, rx, ry, rwe, "R1 random");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule